// File: doc/BRIEF.md
# Two-Wire Half-Duplex Serial Port Controller

This block is the host end of a serial link that carries 16-bit words over a single shared data line, a serial clock and an active-low frame select. On the system side it takes one command at a time. The command gives the direction, a word count, the framing style and the clock divider. The controller then runs that many back-to-back frames on the serial side. For write frames it drives the data line. For read frames it leaves the line to the peripheral and samples it. The shared line is split into an output, an output enable and an input, so the pad ring can build the tri-state buffer.

Two framing styles are supported. In pulsed framing, select goes low for exactly sixteen clock pulses around each word and returns high between words. In tied framing, select stays low once the command has been accepted, and only the count of sixteen rising edges marks the word boundary. A burst keeps one direction from its first word to its last and cannot be cut short. A write burst that follows a period in which the peripheral owned the line first waits a turnaround gap, and only then drives.

The state machine has six states:
- `ST_IDLE` accepts a command.
- `ST_TURN` waits out the turnaround gap.
- `ST_LEAD` holds select low with the clock high before the first falling edge.
- `ST_LOW` is the low half of a clock pulse. It is entered on a falling edge.
- `ST_HIGH` is the high half of a clock pulse. It is entered on a rising edge.
- `ST_TRAIL` holds select high between words in pulsed framing.

The transitions are:
- IDLE→TURN when a write is accepted while the line is an input.
- IDLE→LEAD for any other accepted command.
- TURN→LEAD when the gap has expired.
- LEAD→LOW on the first falling edge of a word.
- LOW→HIGH on every rising edge.
- HIGH→LOW for the second and later bits.
- HIGH→TRAIL after the sixteenth bit in pulsed framing.
- HIGH→LEAD after the sixteenth bit in tied framing when more words remain.
- HIGH→IDLE after the sixteenth bit in tied framing when the burst is complete.
- TRAIL→LEAD when more words remain.
- TRAIL→IDLE when the burst is complete.

Top module: `twc_ctrl`

## Requirements
- R1: After reset, `busy`, `sdo_oe` and `rx_valid` are 0, and `sclk` and `sync_n` are 1.
- R2: Every word is carried by exactly 16 clock pulses, most significant bit first. During a write, `sdo` changes only on falling `sclk` edges, so it is stable at every rising edge.
- R3: Bit `MODE_BIT` (default 13) of every transmitted word is 1, whatever `tx_data` holds. All other bits equal `tx_data`.
- R4: In a read, the line is sampled on each rising edge. After the 16th rising edge, `rx_data` holds the word, first-sampled bit as bit 15, and `rx_valid` is high for one cycle.
- R5: Each half of a clock pulse lasts `clk_div`+1 system clocks. `sclk` is high whenever `busy` is 0.
- R6: In pulsed framing (`cmd_tied`=0), `sync_n` is low for exactly 16 rising edges per word and goes high between words and when idle.
- R7: In tied framing (`cmd_tied`=1), `sync_n` is low from the cycle after acceptance and stays low through the whole burst and after it.
- R8: In a write burst, `sdo_oe` rises on the first falling edge. It stays 1 between words and drops on the 16th rising edge of the final word.
- R9: In a read burst, `sdo_oe` stays 0, and exactly `cmd_len` words are returned with `rx_valid`.
- R10: The time from `busy` rising to the first falling edge is one half period. A write accepted after reset or after a read burst adds 2×`TURN_GAP` half periods of turnaround.
- R11: `busy` stays 1 from acceptance until the last word has finished. A command offered while `busy` is 1 is not merged into the running burst. It is accepted afterwards as a burst of its own.
- R12: `tx_next` pulses once per write word, in the cycle after that word was loaded, so the host can present the next word.
- R13: A `cmd_len` of 0 runs a single word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered; taken when `busy` is 0 |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_len | input | $clog2(MAX_LEN+1) | Number of words in the burst |
| cmd_tied | input | 1 | 1 = select held low, 0 = select pulsed per word |
| clk_div | input | DIV_W | Half period of the serial clock, minus one, in system clocks |
| tx_data | input | DATA_W | Word to be sent next |
| tx_next | output | 1 | Pulse: the current `tx_data` was taken |
| rx_data | output | DATA_W | Last word received |
| rx_valid | output | 1 | Pulse: `rx_data` holds a new word |
| busy | output | 1 | A burst is running |
| sclk | output | 1 | Serial clock |
| sync_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Data toward the shared line |
| sdo_oe | output | 1 | Drive enable for the shared line |
| sdi | input | 1 | Data from the shared line |

## Verification
The bench sweeps both directions, both framing styles, three divider values and burst lengths from one to four. This makes the turnaround decision meet every predecessor. A design that dropped or duplicated the gap would move the first falling edge by exactly 2×`TURN_GAP` half periods. A design that released the line between burst words, or only after the burst, would show `sdo_oe` low at a rising edge other than the final one. Word patterns of all zeros and all ones catch a missing mode bit and swapped bit order. A command held on the port during a running burst would show up as extra pulses or extra words if the controller merged it. A too-short length decode would show up on a zero-length command.

// File: rtl/twc_pkg.sv
package twc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL
    } twc_state_e;

endpackage

// File: rtl/twc_tick.sv
// Half-period timer: tick is high in the last system cycle of each half period.
module twc_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/twc_shift.sv
// Shared shift register: loads and shifts out on falling edges,
// shifts in on rising edges.
module twc_shift #(
    parameter int DATA_W   = 16,
    parameter int MODE_BIT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_out,
    input  logic              shift_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_strobe
);

    localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(1) << MODE_BIT;

    logic [DATA_W-1:0] sh_q;

    assign sdo = sh_q[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= tx_word | MODE_MASK;
        end else if (shift_out) begin
            sh_q <= {sh_q[DATA_W-2:0], 1'b0};
        end else if (shift_in) begin
            sh_q <= {sh_q[DATA_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word   <= '0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= capture;
            if (capture) begin
                rx_word <= {sh_q[DATA_W-2:0], sdi};
            end
        end
    end

endmodule

// File: rtl/twc_ctrl.sv
module twc_ctrl
    import twc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MAX_LEN  = 8,
    parameter int DIV_W    = 8,
    parameter int TURN_GAP = 1,
    parameter int MODE_BIT = 13,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_tied,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_next,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              sclk,
    output logic              sync_n,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);

    localparam int BIT_W       = $clog2(DATA_W);
    localparam int TURN_HALVES = 2 * TURN_GAP;
    localparam int TH_W        = $clog2(TURN_HALVES + 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);
    localparam logic [TH_W-1:0]  TURN_LAST = TH_W'(TURN_HALVES - 1);
    localparam logic [LEN_W-1:0] ONE_WORD  = LEN_W'(1);

    twc_state_e st_q, st_d;

    logic              tick;
    logic              accept;
    logic              fall_ev, rise_ev;
    logic              word_end;
    logic              wr_q, tied_q, line_in_q, oe_q, tx_next_q;
    logic [DIV_W-1:0]  div_q;
    logic [LEN_W-1:0]  words_q;
    logic [BIT_W-1:0]  bit_q;
    logic [TH_W-1:0]   half_q;

    // ---------------- timer ----------------
    twc_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q != ST_IDLE),
        .div   (div_q),
        .tick  (tick)
    );

    // ---------------- events ----------------
    assign accept   = (st_q == ST_IDLE) && cmd_valid;
    assign rise_ev  = tick && (st_q == ST_LOW);
    assign fall_ev  = tick && ((st_q == ST_LEAD) ||
                               ((st_q == ST_HIGH) && (bit_q != LAST_BIT)));
    assign word_end = tick && (st_q == ST_HIGH) && (bit_q == LAST_BIT);

    // ---------------- datapath ----------------
    twc_shift #(.DATA_W(DATA_W), .MODE_BIT(MODE_BIT)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fall_ev && wr_q && (st_q == ST_LEAD)),
        .shift_out (fall_ev && wr_q && (st_q == ST_HIGH)),
        .shift_in  (rise_ev && !wr_q),
        .capture   (rise_ev && !wr_q && (bit_q == LAST_BIT)),
        .tx_word   (tx_data),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_word   (rx_data),
        .rx_strobe (rx_valid)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    st_d = (cmd_write && line_in_q) ? ST_TURN : ST_LEAD;
                end
            end
            ST_TURN: begin
                if (tick && (half_q == TURN_LAST)) begin
                    st_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    st_d = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    st_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (bit_q != LAST_BIT) begin
                        st_d = ST_LOW;
                    end else if (!tied_q) begin
                        st_d = ST_TRAIL;
                    end else if (words_q == ONE_WORD) begin
                        st_d = ST_IDLE;
                    end else begin
                        st_d = ST_LEAD;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    st_d = (words_q == '0) ? ST_IDLE : ST_LEAD;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- control registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            tied_q    <= 1'b0;
            line_in_q <= 1'b1;
            oe_q      <= 1'b0;
            tx_next_q <= 1'b0;
            div_q     <= '0;
            words_q   <= '0;
            bit_q     <= '0;
            half_q    <= '0;
        end else begin
            tx_next_q <= fall_ev && wr_q && (st_q == ST_LEAD);
            if (accept) begin
                wr_q    <= cmd_write;
                tied_q  <= cmd_tied;
                div_q   <= clk_div;
                words_q <= (cmd_len == '0) ? ONE_WORD : cmd_len;
                half_q  <= '0;
                if (!cmd_write) begin
                    line_in_q <= 1'b1;
                end
            end
            if (tick && (st_q == ST_TURN)) begin
                half_q <= half_q + 1'b1;
            end
            if (tick && (st_q == ST_LEAD)) begin
                bit_q <= '0;
            end else if (fall_ev) begin
                bit_q <= bit_q + 1'b1;
            end
            if (word_end) begin
                words_q <= words_q - 1'b1;
            end
            if (fall_ev && wr_q) begin
                oe_q      <= 1'b1;
                line_in_q <= 1'b0;
            end else if (rise_ev && wr_q && (bit_q == LAST_BIT) &&
                         (words_q == ONE_WORD)) begin
                oe_q <= 1'b0;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy    = (st_q != ST_IDLE);
        sclk    = (st_q != ST_LOW);
        sdo_oe  = oe_q;
        tx_next = tx_next_q;
        if (tied_q) begin
            sync_n = 1'b0;
        end else begin
            sync_n = !((st_q == ST_LEAD) || (st_q == ST_LOW) || (st_q == ST_HIGH));
        end
    end

endmodule

// File: rtl/twc_ctrl_chk.sv
module twc_ctrl_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sclk,
    input logic             sync_n,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             rx_valid,
    input logic             tied_q,
    input logic [LEN_W-1:0] words_q
);

    a_r5_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    a_r8_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdo_oe);

    a_r8_drive_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sclk);

    a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && sdo_oe && $past(sdo_oe)) |-> $stable(sdo));

    a_r4_rx_on_rise_as_input: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!sdo_oe && $rose(sclk)));

    a_r6_select_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!tied_q && !sclk) |-> !sync_n);

    a_r7_tied_select_low: assert property (@(posedge clk) disable iff (!rst_n)
        tied_q |-> !sync_n);

    a_r11_no_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (words_q <= $past(words_q)));

endmodule

bind twc_ctrl twc_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sclk     (sclk),
    .sync_n   (sync_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rx_valid (rx_valid),
    .tied_q   (tied_q),
    .words_q  (words_q)
);

// File: tb/sim_twc_ctrl.sv
module sim_twc_ctrl;

    localparam int DW = 16;
    localparam int ML = 8;
    localparam int LW = $clog2(ML + 1);
    localparam int DVW = 8;
    localparam int TG = 1;
    localparam int MB = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_tied = 1'b0;
    logic [DVW-1:0] clk_div = '0;
    logic [DW-1:0] tx_data;
    logic          tx_next, rx_valid, busy, sclk, sync_n, sdo, sdo_oe;
    logic          sdi = 1'b0;
    logic [DW-1:0] rx_data;

    twc_ctrl #(.DATA_W(DW), .MAX_LEN(ML), .DIV_W(DVW), .TURN_GAP(TG), .MODE_BIT(MB)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_len(cmd_len), .cmd_tied(cmd_tied), .clk_div(clk_div), .tx_data(tx_data),
        .tx_next(tx_next), .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
        .sclk(sclk), .sync_n(sync_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected-side settings, written by the stimulus only
    logic [DW-1:0] pat [0:7];
    bit m_wr, m_tied;
    int m_len, m_h;

    // monitor state, written by the monitor only
    int cyc = 0, tx_idx = 0, rx_cnt = 0, rd_idx = 0, rd_bit = 0;
    int rises = 0, frame_rises = 0, bad_sync = 0, bad_half = 0, bad_oe = 0;
    int oe_low_rises = 0, tied_bad = 0, last_fall = 0, first_fall = 0, busy_rise = 0;
    bit seen_fall = 0, p_sclk = 1, p_busy = 0, p_sync = 1;
    logic [DW-1:0] cap_sh = '0;
    logic [DW-1:0] cap [0:7];
    logic [DW-1:0] rxw [0:7];

    assign tx_data = pat[tx_idx[2:0]];

    always @(negedge clk) begin
        cyc++;
        if (busy && !p_busy) begin
            busy_rise = cyc; rises = 0; frame_rises = 0; seen_fall = 0;
            oe_low_rises = 0; bad_sync = 0; bad_half = 0; bad_oe = 0; tied_bad = 0;
            tx_idx = 0; rx_cnt = 0; rd_idx = 0; rd_bit = 0;
        end
        if (p_sclk && !sclk) begin
            if (!seen_fall) begin first_fall = cyc; seen_fall = 1; end
            last_fall = cyc;
            if (!m_wr) begin
                sdi = pat[rd_idx[2:0]][15 - rd_bit];
                rd_bit++;
                if (rd_bit == 16) begin rd_bit = 0; rd_idx++; end
            end
        end
        if (!p_sclk && sclk) begin
            if (cyc - last_fall != m_h) bad_half++;
            rises++; frame_rises++;
            if (m_wr) begin
                cap_sh = {cap_sh[DW-2:0], sdo};
                if (rises % 16 == 0 && rises <= 128) cap[rises/16 - 1] = cap_sh;
                if (!sdo_oe) oe_low_rises++;
            end else if (sdo_oe) begin
                bad_oe++;
            end
            if (!m_tied && sync_n) bad_sync++;
        end
        if (m_wr && seen_fall && busy && rises < 16 * m_len && !sdo_oe) bad_oe++;
        if (!m_wr && sdo_oe) bad_oe++;
        if (p_busy && !p_sync && sync_n && !m_tied) begin
            if (frame_rises != 16) bad_sync++;
            frame_rises = 0;
        end
        if (busy && m_tied && sync_n) tied_bad++;
        if (tx_next) tx_idx++;
        if (rx_valid) begin
            if (rx_cnt < 8) rxw[rx_cnt] = rx_data;
            rx_cnt++;
        end
        p_sclk = sclk; p_busy = busy; p_sync = sync_n;
    end

    bit prev_in = 1;

    task automatic fill(input int variant, input int len, input int div);
        for (int i = 0; i < 8; i++) begin
            if (variant == 1) pat[i] = (i % 2 == 1) ? 16'hFFFF : 16'h0000;
            else pat[i] = 16'((i + 1) * 40503 + len * 273 + div * 4099);
        end
    endtask

    task automatic issue(input bit wr, input int len, input bit tied, input int div);
        m_wr = wr; m_tied = tied; m_h = div + 1;
        m_len = (len == 0) ? 1 : len;
        cmd_write = wr; cmd_len = LW'(len); cmd_tied = tied; clk_div = DVW'(div);
        cmd_valid = 1'b1;
        @(negedge clk);
        while (!busy) @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic verify(input bit wr, input bit tied, input bit gap);
        int exp_lat;
        chk(rises == 16 * m_len, "R2 pulse count", rises, 16 * m_len);
        chk(bad_half == 0, "R5 half period", bad_half, 0);
        chk(sclk == 1'b1, "R5 idle clock", sclk, 1);
        exp_lat = m_h * (1 + (gap ? 2 * TG : 0));
        chk(first_fall - busy_rise == exp_lat, "R10 first edge latency", first_fall - busy_rise, exp_lat);
        if (wr) begin
            for (int i = 0; i < m_len; i++) begin
                chk(cap[i] == (pat[i] | 16'(1 << MB)), "R2 R3 written word", cap[i], pat[i] | 16'(1 << MB));
            end
            chk(tx_idx == m_len, "R12 tx_next count", tx_idx, m_len);
            chk(oe_low_rises == 1 && bad_oe == 0, "R8 drive window", oe_low_rises * 256 + bad_oe, 256);
            chk(sdo_oe == 1'b0, "R8 released after burst", sdo_oe, 0);
        end else begin
            chk(rx_cnt == m_len && bad_oe == 0, "R9 read burst count/direction", rx_cnt * 256 + bad_oe, m_len * 256);
            for (int i = 0; i < m_len; i++) begin
                chk(rxw[i] == pat[i], "R4 received word", rxw[i], pat[i]);
            end
        end
        if (tied) chk(tied_bad == 0 && sync_n == 1'b0, "R7 select held low", tied_bad * 2 + sync_n, 0);
        else chk(bad_sync == 0 && sync_n == 1'b1, "R6 select framing", bad_sync * 2 + (sync_n ? 0 : 1), 0);
    endtask

    task automatic run(input bit wr, input int len, input bit tied, input int div, input int variant);
        bit gap;
        @(negedge clk);
        fill(variant, len, div);
        gap = wr && prev_in;
        issue(wr, len, tied, div);
        while (busy) @(negedge clk);
        @(negedge clk);
        verify(wr, tied, gap);
        prev_in = !wr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && sdo_oe == 0 && rx_valid == 0, "R1 reset outputs low", {busy, sdo_oe, rx_valid}, 0);
        chk(sclk == 1 && sync_n == 1, "R1 reset outputs high", {sclk, sync_n}, 3);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: framing x divider x direction x length
        for (int t = 0; t < 2; t++) begin
            for (int d = 0; d < 3; d++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int l = 1; l <= 4; l++) begin
                        run(w[0], l, t[0], (d == 2) ? 3 : d, 0);
                    end
                end
            end
        end

        // R3 R4: all-zero and all-one words
        run(1'b1, 2, 1'b0, 1, 1);
        run(1'b0, 2, 1'b0, 1, 1);

        // R13: zero length runs one word
        run(1'b1, 0, 1'b0, 0, 0);
        chk(tx_idx == 1, "R13 zero length is one word", tx_idx, 1);

        // R11: command held while busy is a separate burst afterwards
        @(negedge clk);
        fill(0, 2, 1);
        issue(1'b1, 2, 1'b0, 1);
        repeat (5) @(negedge clk);
        cmd_write = 1'b0; cmd_len = LW'(3); cmd_valid = 1'b1;
        chk(busy == 1'b1, "R11 busy during burst", busy, 1);
        while (busy) @(negedge clk);
        chk(rises == 32 && tx_idx == 2, "R11 first burst not merged", rises, 32);
        chk(cap[0] == (pat[0] | 16'(1 << MB)) && cap[1] == (pat[1] | 16'(1 << MB)),
            "R11 first burst words", cap[1], pat[1] | 16'(1 << MB));
        m_wr = 1'b0; m_len = 3;
        @(negedge clk);
        while (!busy) @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(rx_cnt == 3 && rises == 48, "R11 held command ran alone", rx_cnt, 3);
        for (int i = 0; i < 3; i++) chk(rxw[i] == pat[i], "R11 R4 held read word", rxw[i], pat[i]);
        chk(bad_oe == 0, "R9 held read kept line as input", bad_oe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule